// File: doc/BRIEF.md
# Packet Framing Control Generator

This block produces a 2-bit control code, one value per clock, that frames a packet for a downstream consumer. When a start request arrives while the block is free, it captures the packet length (counted in buffers) and the idle gap length N. It then drives one marker cycle for each buffer except the last, and finishes with an end cycle. The first marker is the start of packet and the others are middle markers. Start and middle markers share one code, so a consumer can tell them apart only by where they fall in the packet.

N idle cycles separate each pair of neighbouring markers. The one exception is the end code: it must follow the last middle marker in the very next cycle. With N equal to 0, every marker runs back to back. A length below two buffers cannot hold both a marker and the end code that must follow it, so such a request is refused and the block stays idle. A `busy_o` level covers the whole packet, and `done_o` pulses in the end cycle.

The controller has four states. `ST_IDLE` waits for a request. `ST_MARK` drives a marker. `ST_GAP` drives idle cycles between markers. `ST_END` drives the end code. Transitions: IDLE→MARK on an accepted request; MARK→END when the marker just driven is the last one; MARK→MARK when N is 0; MARK→GAP otherwise; GAP→GAP while idle cycles remain; GAP→MARK on the last idle cycle; END→IDLE always.

Top module: `pkt_frame_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `code_o` is 2'b00, `busy_o` is 0 and `done_o` is 0.
- R2: A request (`start_i` high at a rising edge while `busy_o` is low and `len_i` >= 2) is accepted. From the next cycle on, `busy_o` is 1 and `code_o` is the marker code 2'b01.
- R3: The code values are 2'b00 for idle, 2'b01 for a start or middle marker and 2'b11 for the end. The value 2'b10 never appears.
- R4: Between two marker cycles of one packet there are exactly N cycles of 2'b00, where N is the `gap_i` value captured when the request was accepted.
- R5: A packet of L buffers drives exactly L-1 cycles of 2'b01 and then one cycle of 2'b11. The 2'b11 cycle comes directly after the last 2'b01 cycle, with no idle between them.
- R6: `done_o` is high for exactly the end cycle. In the cycle after it, `busy_o` is 0 and `code_o` is 2'b00.
- R7: A request with `len_i` of 0 or 1 is refused. `busy_o` stays 0 and `code_o` stays 2'b00.
- R8: While `busy_o` is high, `start_i`, `len_i` and `gap_i` have no effect on the packet in progress.
- R9: With N = 0, all marker cycles of a packet are consecutive.
- R10: A packet of 2 buffers is one 2'b01 cycle followed at once by 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Packet request |
| len_i | input | LEN_W | Packet length in buffers |
| gap_i | input | GAP_W | Idle cycles between markers (N) |
| code_o | output | 2 | Framing control code |
| busy_o | output | 1 | High from the first marker through the end cycle |
| done_o | output | 1 | One-cycle pulse in the end cycle |

## Verification
The bench builds the block with LEN_W = 4 and GAP_W = 3. These small widths put the longest packet (15 buffers) and the widest gap (7 idle cycles) within reach, so the extreme lengths and gaps are run as well as the typical ones. The vectors cover minimum-length packets, zero gaps, requests made during a packet, and refused lengths of 0 and 1. Every cycle of each packet is compared with a model built from the requirements.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_GAP  = 2'd2,
        ST_END  = 2'd3
    } fsm_state_t;

    typedef enum logic [1:0] {
        CODE_IDLE = 2'b00,
        CODE_MARK = 2'b01,
        CODE_END  = 2'b11
    } frame_code_t;

    localparam int unsigned MIN_LEN = 2;

endpackage

// File: rtl/pkt_frame_cnt.sv
// Loadable down counter with a flag that marks the value one.
module pkt_frame_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign at_one = (cnt_q == ONE);
endmodule

// File: rtl/pkt_frame_ctrl.sv
// State machine that sequences markers, gaps and the end code.
module pkt_frame_ctrl
    import pkt_frame_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             mark_last,
    input  logic             gap_last,
    output logic             mark_load,
    output logic [LEN_W-1:0] mark_load_val,
    output logic             mark_dec,
    output logic             gap_load,
    output logic [GAP_W-1:0] gap_load_val,
    output logic             gap_dec,
    output fsm_state_t       state,
    output logic             busy,
    output logic             done
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fsm_state_t       state_q, state_d;
    logic [GAP_W-1:0] gap_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i && (len_i >= LEN_MIN);

    // State register and captured gap length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                gap_q <= gap_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_MARK;
            ST_MARK: begin
                if (mark_last)        state_d = ST_END;
                else if (gap_q == '0) state_d = ST_MARK;
                else                  state_d = ST_GAP;
            end
            ST_GAP:  if (gap_last) state_d = ST_MARK;
            ST_END:  state_d = ST_IDLE;
        endcase
    end

    // Output and counter-control decode
    always_comb begin
        mark_load     = accept;
        mark_load_val = len_i - LEN_ONE;
        mark_dec      = 1'b0;
        gap_load      = 1'b0;
        gap_load_val  = gap_q;
        gap_dec       = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_MARK: begin
                mark_dec = 1'b1;
                gap_load = 1'b1;
            end
            ST_GAP:  gap_dec = 1'b1;
            ST_END:  done = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pkt_frame_enc.sv
// Maps controller state to the framing code on the wire.
module pkt_frame_enc
    import pkt_frame_pkg::*;
(
    input  fsm_state_t  state,
    output logic [1:0]  code
);
    frame_code_t c;

    always_comb begin
        unique case (state)
            ST_IDLE: c = CODE_IDLE;
            ST_MARK: c = CODE_MARK;
            ST_GAP:  c = CODE_IDLE;
            ST_END:  c = CODE_END;
        endcase
    end

    assign code = c;
endmodule

// File: rtl/pkt_frame_gen.sv
module pkt_frame_gen
    import pkt_frame_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic [1:0]       code_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             mark_last, gap_last;
    logic             mark_load, mark_dec, gap_load, gap_dec;
    logic [LEN_W-1:0] mark_load_val;
    logic [GAP_W-1:0] gap_load_val;
    fsm_state_t       state;

    pkt_frame_ctrl #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .len_i         (len_i),
        .gap_i         (gap_i),
        .mark_last     (mark_last),
        .gap_last      (gap_last),
        .mark_load     (mark_load),
        .mark_load_val (mark_load_val),
        .mark_dec      (mark_dec),
        .gap_load      (gap_load),
        .gap_load_val  (gap_load_val),
        .gap_dec       (gap_dec),
        .state         (state),
        .busy          (busy_o),
        .done          (done_o)
    );

    pkt_frame_cnt #(.W(LEN_W)) u_mark_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mark_load),
        .load_val (mark_load_val),
        .dec      (mark_dec),
        .at_one   (mark_last)
    );

    pkt_frame_cnt #(.W(GAP_W)) u_gap_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_load_val),
        .dec      (gap_dec),
        .at_one   (gap_last)
    );

    pkt_frame_enc u_enc (
        .state (state),
        .code  (code_o)
    );
endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk #(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] len_i,
    input logic [GAP_W-1:0] gap_i,
    input logic [1:0]       code_o,
    input logic             busy_o,
    input logic             done_o
);
    logic [GAP_W:0]   idle_run;
    logic [GAP_W-1:0] gap_lat;
    logic             seen_mark;
    logic             req_ok;

    assign req_ok = !busy_o && start_i && (len_i >= LEN_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_run  <= '0;
            gap_lat   <= '0;
            seen_mark <= 1'b0;
        end else begin
            if (req_ok) gap_lat <= gap_i;
            if (!busy_o) begin
                seen_mark <= 1'b0;
                idle_run  <= '0;
            end else if (code_o == 2'b01) begin
                seen_mark <= 1'b1;
                idle_run  <= '0;
            end else if (code_o == 2'b00 && idle_run != '1) begin
                idle_run  <= idle_run + 1'b1;
            end
        end
    end

    p_no_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_o != 2'b10);

    p_accept_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |=> (busy_o && code_o == 2'b01));

    p_gap_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && code_o == 2'b01 && seen_mark) |-> (idle_run == {1'b0, gap_lat}));

    p_end_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 2'b11) |-> ($past(code_o) == 2'b01));

    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_o == 2'b11));

    p_free_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 2'b11) |=> (!busy_o && code_o == 2'b00));

    p_short_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && len_i < LEN_W'(2)) |=> !busy_o);

    p_idle_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (code_o == 2'b00 && !done_o));
endmodule

bind pkt_frame_gen pkt_frame_chk #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .len_i   (len_i),
    .gap_i   (gap_i),
    .code_o  (code_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/pkt_frame_gen_tb_top.sv
module pkt_frame_gen_tb_top;
    localparam int LEN_W = 4;
    localparam int GAP_W = 3;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [GAP_W-1:0] gap;
        logic             poke;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd4,  3'd2, 1'b0},
        '{4'd2,  3'd0, 1'b0},
        '{4'd2,  3'd5, 1'b0},
        '{4'd5,  3'd0, 1'b0},
        '{4'd3,  3'd1, 1'b1},
        '{4'd15, 3'd7, 1'b0},
        '{4'd6,  3'd3, 1'b1},
        '{4'd4,  3'd1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [GAP_W-1:0] gap_i = '0;
    logic [1:0]       code_o;
    logic             busy_o, done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pkt_frame_gen #(.LEN_W(LEN_W), .GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .gap_i(gap_i), .code_o(code_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [1:0] exp_code(int t, int L, int N);
        int pos = 0;
        for (int m = 0; m < L - 1; m++) begin
            if (t == pos) return 2'b01;
            if (m == L - 2) begin
                if (t == pos + 1) return 2'b11;
            end else begin
                pos += 1 + N;
            end
        end
        return 2'b00;
    endfunction

    // Requests one packet, optionally pokes the inputs while busy (R8),
    // and compares every cycle against the model (R2 R3 R4 R5 R6 R9 R10).
    task automatic run_pkt(input int L, input int N, input bit poke);
        int total = (L - 1) + (L - 2) * N + 1;
        start_i = 1'b1;
        len_i   = LEN_W'(L);
        gap_i   = GAP_W'(N);
        @(negedge clk);
        start_i = 1'b0;
        len_i   = '0;
        gap_i   = GAP_W'(N + 3);
        for (int t = 0; t < total; t++) begin
            logic [1:0] e = exp_code(t, L, N);
            check(code_o == e, (t == 0) ? "R2" : (e == 2'b11) ? "R5" : "R4",
                  code_o, e);
            check(busy_o == 1'b1, "R2", busy_o, 1);
            check(done_o == (t == total - 1), "R6", done_o, (t == total - 1));
            start_i = poke && (t == 1);
            len_i   = poke ? LEN_W'(3) : '0;
            @(negedge clk);
            start_i = 1'b0;
        end
        check(busy_o == 1'b0, "R6", busy_o, 0);
        check(code_o == 2'b00, "R6", code_o, 0);
        check(done_o == 1'b0, "R6", done_o, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(code_o == 2'b00, "R1", code_o, 0);
        check(busy_o == 1'b0, "R1", busy_o, 0);
        check(done_o == 1'b0, "R1", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(code_o == 2'b00 && !busy_o, "R1", code_o, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_pkt(int'(VECS[i].len), int'(VECS[i].gap), VECS[i].poke);
        end

        // R7: lengths 0 and 1 are refused
        for (int l = 0; l < 2; l++) begin
            start_i = 1'b1;
            len_i   = LEN_W'(l);
            gap_i   = 3'd1;
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < 3; k++) begin
                check(!busy_o, "R7", busy_o, 0);
                check(code_o == 2'b00, "R7", code_o, 0);
                @(negedge clk);
            end
        end

        // R10 then R9 back to back with no spare cycle
        run_pkt(2, 7, 1'b0);
        run_pkt(7, 0, 1'b1);

        // R1: reset in the middle of a packet
        start_i = 1'b1;
        len_i   = 4'd9;
        gap_i   = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && code_o == 2'b00 && !done_o, "R1", code_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && code_o == 2'b00, "R1", busy_o, 0);
        run_pkt(3, 2, 1'b0);

        report();
    end
endmodule